// File: doc/BRIEF.md
# Two-Way Data Cache Tag Controller

This block keeps the tags, line states and replacement bits for a two-way set-associative primary data cache. A requester presents a physical address with a read or write flag. The controller splits the address into an offset, a set index and a tag, and compares the tag with both ways of the selected set. One cycle later it gives a registered response. The response is a hit, a plain miss or an upgrade miss, and it names a way. The data array, the refill path and the bus protocol sit outside this block. Only tag words and one replacement bit per set are held here.

Each tag word holds the line state in two flag bits above the tag. The top bit means the way holds nothing. The bit below it means the line is owned exclusively. A fill writes a tag with the ownership flag set from its own input. A snoop port lets the level below take ownership away (downgrade) or remove a line (invalidate). A miss or an upgrade miss stops the controller in a waiting state. While it waits, it refuses new lookups. It leaves that state once the level below has returned the missing line with the right ownership.

The control has two states. `ST_IDLE` accepts lookups. `ST_WAIT` ignores lookups while a miss is outstanding. The transition `miss_taken` (ST_IDLE to ST_WAIT) fires when an accepted lookup misses or upgrade-misses. The transition `fill_done` (ST_WAIT to ST_IDLE) fires on a fill of the pending line whose ownership satisfies the request. All other cases hold the state.

Top module: `dcache_tag_ctrl`

## Requirements
- R1: Reset empties every way, points every replacement bit at way 0, enters `ST_IDLE` and drives all response outputs and `busy` low. A reset taken while a miss is pending also clears `busy`.
- R2: With the default widths (32-bit address, 32-byte lines, 64 sets) the set index is address bits [10:5] and the tag is bits [31:11]. Offset bits [4:0] have no effect on the result. The same tag in a different set is a different line.
- R3: A lookup accepted at a clock edge produces `rsp_valid` for exactly the next cycle, with exactly one of `rsp_hit`, `rsp_miss`, `rsp_upgrade` high. Without an accepted lookup all response outputs are low.
- R4: A read hits when a valid way, shared or exclusive, holds the tag. `rsp_way` names that way, and the set's replacement bit then points at the other way.
- R5: A write hits only on an exclusive line. A write matching a shared line is an upgrade miss naming the matching way, and it leaves the replacement bit alone. A write with no match is a plain miss.
- R6: A miss or an upgrade miss raises `busy` in the response cycle. While busy, lookups get no response. `busy` falls only after a fill of the pending line (same tag and index). For a pending write that fill must be exclusive; a shared fill keeps `busy` high.
- R7: A fill goes into the valid way already holding its tag if there is one. Otherwise it goes into way 0 if that way is empty, then way 1 if empty, else the way the replacement bit names. It stores the tag with ownership equal to `fill_excl`, and the replacement bit then points at the other way.
- R8: On a plain miss, `rsp_way` names the way that a fill of that line would take under R7.
- R9: A downgrade snoop (`snp_inval` = 0) on a present line removes exclusive ownership and keeps the line valid. Reads still hit and writes become upgrade misses.
- R10: An invalidate snoop (`snp_inval` = 1) on a present line empties its way, so later lookups miss. A snoop whose tag is in neither way changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | 1 = write lookup, 0 = read lookup |
| req_addr | input | ADDR_W | Lookup physical address |
| fill_valid | input | 1 | Install a line |
| fill_excl | input | 1 | Installed line is owned exclusively |
| fill_addr | input | ADDR_W | Address of the installed line |
| snp_valid | input | 1 | Snoop command from the level below |
| snp_inval | input | 1 | 1 = invalidate, 0 = downgrade |
| snp_addr | input | ADDR_W | Snooped address |
| busy | output | 1 | Miss outstanding; lookups ignored |
| rsp_valid | output | 1 | Registered lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Line absent |
| rsp_upgrade | output | 1 | Write found only a shared copy |
| rsp_way | output | 1 | Matching way, or victim way on a plain miss |

## Verification
The properties assume that the level below never raises `fill_valid` and `snp_valid` in the same cycle, and that it only fills lines that were missed or that it is upgrading. The stimulus keeps to this assumption by driving exactly one command per operation and releasing it before the response is sampled. Under this assumption the fill priority over snoops is never exercised. The properties also assume a lookup is held for a single cycle, so that each response maps to one accepted request. Lookups sent while `busy` is high are deliberate. They check that the controller discards them, not that the requester is well behaved.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } dct_state_e;

    localparam int WAYS  = 2;
    localparam int NPORT = 3;
    localparam int P_LK  = 0;
    localparam int P_FL  = 1;
    localparam int P_SN  = 2;
endpackage

// File: rtl/dct_addr_split.sv
module dct_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic unused_off;

    assign idx        = addr[OFF_W +: IDX_W];
    assign tag        = addr[ADDR_W-1 : OFF_W+IDX_W];
    assign unused_off = ^addr[OFF_W-1:0];
endmodule

// File: rtl/dct_way_cmp.sv
module dct_way_cmp #(
    parameter int TAG_W = 21,
    localparam int TW   = TAG_W + 2
) (
    input  logic [TW-1:0]    word,
    input  logic [TAG_W-1:0] tag,
    output logic             present,
    output logic             excl
);
    // word[TW-1] = empty flag, word[TW-2] = ownership flag
    assign present = !word[TW-1] && (word[TAG_W-1:0] == tag);
    assign excl    = present && word[TW-2];
endmodule

// File: rtl/dct_tag_store.sv
module dct_tag_store #(
    parameter int SETS  = 64,
    parameter int TAG_W = 21,
    parameter int NRD   = 3,
    localparam int IDX_W = $clog2(SETS),
    localparam int TW    = TAG_W + 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]        rd_idx,
    output logic [NRD-1:0][1:0][TW-1:0]      rd_words,
    output logic [NRD-1:0]                   rd_lru,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic                             wr_way,
    input  logic [TW-1:0]                    wr_word,
    input  logic                             lru_en,
    input  logic [IDX_W-1:0]                 lru_idx,
    input  logic                             lru_val
);
    localparam logic [TW-1:0] EMPTY_WORD = {1'b1, {(TW-1){1'b0}}};

    logic [1:0][TW-1:0] words_q [SETS];
    logic [SETS-1:0]    lru_q;

    genvar p;
    generate
        for (p = 0; p < NRD; p++) begin : g_rd
            assign rd_words[p] = words_q[rd_idx[p]];
            assign rd_lru[p]   = lru_q[rd_idx[p]];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                words_q[s] <= {EMPTY_WORD, EMPTY_WORD};
            end
            lru_q <= '0;
        end else begin
            if (wr_en)  words_q[wr_idx][wr_way] <= wr_word;
            if (lru_en) lru_q[lru_idx] <= lru_val;
        end
    end
endmodule

// File: rtl/dct_ctrl_fsm.sv
module dct_ctrl_fsm
    import dct_pkg::*;
#(
    parameter int LINE_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LINE_W-1:0] req_line,
    input  logic              lk_hit,
    input  logic              lk_upg,
    input  logic              lk_way,
    input  logic              fill_valid,
    input  logic              fill_excl,
    input  logic [LINE_W-1:0] fill_line,
    output logic              accept,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_upgrade,
    output logic              rsp_way
);
    dct_state_e        state_q, state_d;
    logic [LINE_W-1:0] pend_line_q;
    logic              pend_excl_q;
    logic              fill_done;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign busy      = (state_q == ST_WAIT);
    assign fill_done = fill_valid && (fill_line == pend_line_q) &&
                       (fill_excl || !pend_excl_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !lk_hit) state_d = ST_WAIT;   // miss_taken
            ST_WAIT: if (fill_done)         state_d = ST_IDLE;   // fill_done
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_line_q <= '0;
            pend_excl_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && !lk_hit) begin
                pend_line_q <= req_line;
                pend_excl_q <= req_write;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_upgrade <= 1'b0;
            rsp_way     <= 1'b0;
        end else begin
            rsp_valid   <= accept;
            rsp_hit     <= accept && lk_hit;
            rsp_miss    <= accept && !lk_hit && !lk_upg;
            rsp_upgrade <= accept && lk_upg;
            rsp_way     <= accept && lk_way;
        end
    end
endmodule

// File: rtl/dcache_tag_ctrl.sv
module dcache_tag_ctrl
    import dct_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fill_valid,
    input  logic              fill_excl,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              snp_valid,
    input  logic              snp_inval,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_upgrade,
    output logic              rsp_way
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int TW      = TAG_W + 2;
    localparam int EMPTY_B = TW - 1;
    localparam int OWN_B   = TW - 2;

    logic [NPORT-1:0][ADDR_W-1:0]      p_addr;
    logic [NPORT-1:0][IDX_W-1:0]       p_idx;
    logic [NPORT-1:0][TAG_W-1:0]       p_tag;
    logic [NPORT-1:0][WAYS-1:0][TW-1:0] p_words;
    logic [NPORT-1:0]                  p_lru;
    logic [NPORT-1:0][WAYS-1:0]        pres;
    logic [NPORT-1:0][WAYS-1:0]        excl;

    logic             lk_hit, lk_upg, lk_way, fl_way, accept;
    logic             wr_en, wr_way, lru_en, lru_val;
    logic [IDX_W-1:0] wr_idx, lru_idx;
    logic [TW-1:0]    wr_word;
    logic             unused_x;

    assign p_addr = {snp_addr, fill_addr, req_addr};

    genvar p, w;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            dct_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
                .addr (p_addr[p]),
                .idx  (p_idx[p]),
                .tag  (p_tag[p])
            );
            for (w = 0; w < WAYS; w++) begin : g_way
                dct_way_cmp #(.TAG_W(TAG_W)) u_cmp (
                    .word    (p_words[p][w]),
                    .tag     (p_tag[p]),
                    .present (pres[p][w]),
                    .excl    (excl[p][w])
                );
            end
        end
    endgenerate

    assign unused_x = ^{excl[P_FL], excl[P_SN], p_lru[P_SN]};

    dct_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .NRD(NPORT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (p_idx),
        .rd_words (p_words),
        .rd_lru   (p_lru),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_way   (wr_way),
        .wr_word  (wr_word),
        .lru_en   (lru_en),
        .lru_idx  (lru_idx),
        .lru_val  (lru_val)
    );

    // Matching way first, then an empty way (way 0 before way 1), then the pointer.
    function automatic logic pick_way(input logic [WAYS-1:0][TW-1:0] words,
                                      input logic [WAYS-1:0] hit_vec,
                                      input logic lru);
        if (|hit_vec)            return hit_vec[1];
        if (words[0][EMPTY_B])   return 1'b0;
        if (words[1][EMPTY_B])   return 1'b1;
        return lru;
    endfunction

    assign lk_hit = req_write ? |excl[P_LK] : |pres[P_LK];
    assign lk_upg = req_write && |pres[P_LK] && !(|excl[P_LK]);
    assign lk_way = pick_way(p_words[P_LK], pres[P_LK], p_lru[P_LK]);
    assign fl_way = pick_way(p_words[P_FL], pres[P_FL], p_lru[P_FL]);

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = p_idx[P_FL];
        wr_way  = fl_way;
        wr_word = {1'b0, fill_excl, p_tag[P_FL]};
        if (fill_valid) begin
            wr_en = 1'b1;
        end else if (snp_valid && |pres[P_SN]) begin
            wr_en   = 1'b1;
            wr_idx  = p_idx[P_SN];
            wr_way  = pres[P_SN][1];
            wr_word = p_words[P_SN][pres[P_SN][1]];
            if (snp_inval) wr_word[EMPTY_B] = 1'b1;
            else           wr_word[OWN_B]   = 1'b0;
        end
    end

    always_comb begin
        lru_en  = 1'b0;
        lru_idx = p_idx[P_FL];
        lru_val = !fl_way;
        if (fill_valid) begin
            lru_en = 1'b1;
        end else if (accept && lk_hit) begin
            lru_en  = 1'b1;
            lru_idx = p_idx[P_LK];
            lru_val = !lk_way;
        end
    end

    dct_ctrl_fsm #(.LINE_W(TAG_W + IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_line    ({p_tag[P_LK], p_idx[P_LK]}),
        .lk_hit      (lk_hit),
        .lk_upg      (lk_upg),
        .lk_way      (lk_way),
        .fill_valid  (fill_valid),
        .fill_excl   (fill_excl),
        .fill_line   ({p_tag[P_FL], p_idx[P_FL]}),
        .accept      (accept),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_miss    (rsp_miss),
        .rsp_upgrade (rsp_upgrade),
        .rsp_way     (rsp_way)
    );
endmodule

// File: rtl/dct_checker.sv
module dct_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic fill_valid,
    input logic busy,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_miss,
    input logic rsp_upgrade
);
    // R3
    onehot_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_upgrade}) == 1));

    // R3
    quiet_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_upgrade));

    // R3
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !busy));

    // R6
    miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> busy);

    // R6
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !rsp_valid);

    // R6
    release_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fill_valid));
endmodule

bind dcache_tag_ctrl dct_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .fill_valid  (fill_valid),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_upgrade (rsp_upgrade)
);

// File: tb/tb_dcache_tag_ctrl.sv
module tb_dcache_tag_ctrl;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          fill_valid = 1'b0, fill_excl = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          snp_valid = 1'b0, snp_inval = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          busy, rsp_valid, rsp_hit, rsp_miss, rsp_upgrade, rsp_way;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    dcache_tag_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_excl(fill_excl), .fill_addr(fill_addr),
        .snp_valid(snp_valid), .snp_inval(snp_inval), .snp_addr(snp_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_upgrade(rsp_upgrade), .rsp_way(rsp_way)
    );

    // Ops: 0 read, 1 write, 2 shared fill, 3 exclusive fill, 4 downgrade, 5 invalidate
    // Entry: {req[3:0], op[2:0], tag[3:0], idx[5:0], off[4:0], exp{valid,hit,miss,upg,way,busy}}
    // Tags: A=1, B=2, C=3.
    localparam int NV = 31;
    localparam logic [27:0] VEC [NV] = '{
        {4'd8,  3'd0, 4'd1, 6'd3, 5'd0,  6'b101001}, // R8 read A miss -> empty way 0
        {4'd6,  3'd0, 4'd2, 6'd3, 5'd0,  6'b000001}, // R6 lookup ignored while busy
        {4'd7,  3'd2, 4'd1, 6'd3, 5'd0,  6'b000000}, // R7 fill A shared, way 0
        {4'd4,  3'd0, 4'd1, 6'd3, 5'd0,  6'b110000}, // R4 read hit shared
        {4'd5,  3'd1, 4'd1, 6'd3, 5'd0,  6'b100101}, // R5 write to shared: upgrade
        {4'd6,  3'd2, 4'd1, 6'd3, 5'd0,  6'b000001}, // R6 shared fill keeps write blocked
        {4'd7,  3'd3, 4'd1, 6'd3, 5'd0,  6'b000000}, // R7 exclusive fill in place
        {4'd5,  3'd1, 4'd1, 6'd3, 5'd0,  6'b110000}, // R5 write hit exclusive
        {4'd8,  3'd0, 4'd2, 6'd3, 5'd0,  6'b101011}, // R8 read B miss -> empty way 1
        {4'd7,  3'd2, 4'd2, 6'd3, 5'd0,  6'b000000}, // R7 fill B way 1
        {4'd2,  3'd0, 4'd2, 6'd3, 5'd28, 6'b110010}, // R2 offset bits ignored
        {4'd4,  3'd0, 4'd1, 6'd3, 5'd0,  6'b110000}, // R4 hit way 0 -> pointer way 1
        {4'd8,  3'd1, 4'd3, 6'd3, 5'd0,  6'b101011}, // R8 write C miss -> pointer way 1
        {4'd7,  3'd3, 4'd3, 6'd3, 5'd0,  6'b000000}, // R7 fill C evicts B
        {4'd8,  3'd0, 4'd2, 6'd3, 5'd0,  6'b101001}, // R8 read B miss -> pointer way 0
        {4'd7,  3'd2, 4'd2, 6'd3, 5'd0,  6'b000000}, // R7 fill B evicts A
        {4'd5,  3'd1, 4'd3, 6'd3, 5'd0,  6'b110010}, // R5 write hit C way 1
        {4'd9,  3'd4, 4'd3, 6'd3, 5'd0,  6'b000000}, // R9 downgrade C
        {4'd9,  3'd0, 4'd3, 6'd3, 5'd0,  6'b110010}, // R9 read still hits
        {4'd9,  3'd1, 4'd3, 6'd3, 5'd0,  6'b100111}, // R9 write now upgrades
        {4'd6,  3'd3, 4'd3, 6'd3, 5'd0,  6'b000000}, // R6 exclusive fill releases
        {4'd10, 3'd5, 4'd2, 6'd3, 5'd0,  6'b000000}, // R10 invalidate B
        {4'd10, 3'd0, 4'd2, 6'd3, 5'd0,  6'b101001}, // R10 B now misses, way 0 empty
        {4'd7,  3'd2, 4'd2, 6'd3, 5'd0,  6'b000000}, // R7 refill B way 0
        {4'd10, 3'd5, 4'd1, 6'd3, 5'd0,  6'b000000}, // R10 snoop absent line
        {4'd10, 3'd0, 4'd2, 6'd3, 5'd0,  6'b110000}, // R10 B untouched
        {4'd10, 3'd0, 4'd3, 6'd3, 5'd0,  6'b110010}, // R10 C untouched
        {4'd2,  3'd0, 4'd1, 6'd4, 5'd0,  6'b101001}, // R2 same tag, other set misses
        {4'd7,  3'd2, 4'd1, 6'd4, 5'd0,  6'b000000}, // R7 fill set 4
        {4'd2,  3'd0, 4'd1, 6'd4, 5'd0,  6'b110000}, // R2 set 4 hit
        {4'd2,  3'd0, 4'd2, 6'd3, 5'd0,  6'b110000}  // R2 set 3 unaffected
    };

    function automatic logic [AW-1:0] mk_addr(input logic [3:0] tag,
                                              input logic [5:0] idx,
                                              input logic [4:0] off);
        return {17'd0, tag, idx, off};
    endfunction

    function automatic logic [5:0] observed();
        return {rsp_valid, rsp_hit, rsp_miss, rsp_upgrade, rsp_way, busy};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: {valid,hit,miss,upg,way,busy} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one command for one cycle; the response is visible at the following negedge.
    task automatic do_op(input logic [2:0] op, input logic [AW-1:0] addr);
        @(negedge clk);
        req_valid  = (op <= 3'd1);
        req_write  = (op == 3'd1);
        req_addr   = addr;
        fill_valid = (op == 3'd2) || (op == 3'd3);
        fill_excl  = (op == 3'd3);
        fill_addr  = addr;
        snp_valid  = (op == 3'd4) || (op == 3'd5);
        snp_inval  = (op == 3'd5);
        snp_addr   = addr;
        @(negedge clk);
        req_valid  = 1'b0;
        fill_valid = 1'b0;
        snp_valid  = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        apply_reset();
        // R1 reset state at the ports
        check("R1", observed(), 6'b000000);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string       tag_s;
            v = VEC[i];
            do_op(v[23:21], mk_addr(v[20:17], v[16:11], v[10:6]));
            tag_s = $sformatf("R%0d vec%0d", v[27:24], i);
            check(tag_s, observed(), v[5:0]);
        end

        // R3 response lasts exactly one cycle
        do_op(3'd0, mk_addr(4'd2, 6'd3, 5'd0));
        check("R3 pulse", observed(), 6'b110000);
        @(negedge clk);
        check("R3 drop", observed(), 6'b000000);

        // R1 reset while a miss is pending clears busy and empties the store
        do_op(3'd0, mk_addr(4'd5, 6'd9, 5'd0));
        check("R1 pre", observed(), 6'b101001);
        apply_reset();
        check("R1 busy", observed(), 6'b000000);
        do_op(3'd0, mk_addr(4'd2, 6'd3, 5'd0));
        check("R1 empty", observed(), 6'b101001);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule